// File: doc/BRIEF.md
# Timer Count-Enable Front End with Source Select, Prescaler and Suspend Gating

This block drives one 16-bit down-counting timer channel. A 2-bit select field picks the counting source. Codes 0 to 2 pick one of three tick strobes that are already in the system clock domain. The selected strobe passes through a power-of-two prescaler, whose ratio comes from a 4-bit divide field. Each time the prescaler completes a period, the block issues a single-cycle count enable. That enable decrements the channel counter. The counter reloads from its stored reload value when it steps past zero, and it raises a one-cycle underflow pulse.

Select code 3 depends on a per-channel capability parameter:
- On an event-capable channel, code 3 counts rising edges of an external pin. The pin passes through a synchronizer and an edge detector, and the prescaler is bypassed.
- On any other channel, code 3 selects an alternate oscillator tick, which goes through the prescaler like the other sources.

Counting can be suspended in two cases: during a sleep request when the source is configured to stop in sleep, and in debug state unless the debug-run bit is set. While suspended, both the counter and the prescaler phase are frozen. Counting resumes exactly where it left off.

Top module: `tmr_clk_front`

## Requirements
- R1: After reset, count is 0, underflow is 0, and cnt_en stays 0 while no tick is present.
- R2: With sel of 0, 1 or 2, only src_tick[sel] advances the prescaler. Ticks on the other source lines have no effect on count.
- R3: With divide field d, one cnt_en pulse is issued for every 2^d ticks of the selected source (d = 0 gives one pulse per tick). Each cnt_en pulse on a running counter that is above 0 lowers count by one at the next clock edge.
- R4: A change of sel or div, or a start command, restarts the prescaler phase from zero. No cnt_en is issued in that cycle.
- R5: While sleep_req and stop_in_sleep are both 1, cnt_en is 0. Count and the prescaler phase are kept, so the first tick after wake-up continues the interrupted period.
- R6: While sleep_req is 1 and stop_in_sleep is 0, counting proceeds as if awake.
- R7: While debug_mode is 1 and debug_run is 0, cnt_en is 0. Count and the prescaler phase are kept.
- R8: While debug_mode and debug_run are both 1, counting proceeds normally.
- R9: On an event-capable channel with sel = 3, each rising edge of ev_pin produces one cnt_en. This happens after a two-flop synchronizer, so count drops at the third clock edge after the pin rises. The divide field is not applied, and a pin held high counts once.
- R10: On a channel without event capability, sel = 3 counts alt_tick through the prescaler, and ev_pin is ignored. On an event-capable channel, alt_tick has no effect.
- R11: start loads reload_val into count at the next edge and stores it as the reload value. Before the first start, count does not change.
- R12: A cnt_en while count is 0 loads the stored reload value and sets underflow for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 3 | Tick strobes for select codes 0..2 |
| alt_tick | input | 1 | Alternate oscillator tick strobe (code 3, non-event channel) |
| ev_pin | input | 1 | Asynchronous external event pin (code 3, event channel) |
| sel | input | 2 | Source select |
| div | input | 4 | Divide field; ratio is 2^div |
| sleep_req | input | 1 | Sleep state request |
| stop_in_sleep | input | 1 | Selected source stops in sleep |
| debug_mode | input | 1 | Processor debug state |
| debug_run | input | 1 | Keep counting during debug state |
| start | input | 1 | Run-start command, loads reload_val |
| reload_val | input | 16 | Reload value captured on start |
| cnt_en | output | 1 | Single-cycle count enable |
| count | output | 16 | Current counter value |
| underflow | output | 1 | One-cycle pulse after reload from zero |

## Verification
The bench builds two copies side by side with default widths (16-bit counter, 4-bit divide field, two synchronizer stages). One copy is event-capable and the other is not, so that select code 3 is exercised in both variants against the same stimulus. The random phase keeps the divide field at 0 to 3 and the reload values small. This makes prescaler boundaries, reload wraps and underflow pulses frequent, and lets them overlap with suspend, select changes and start commands.

// File: rtl/tmr_clk_pkg.sv
package tmr_clk_pkg;

  typedef enum logic [1:0] {
    SRC_A   = 2'd0,
    SRC_B   = 2'd1,
    SRC_C   = 2'd2,
    SRC_ALT = 2'd3
  } src_sel_e;

  // Terminal prescaler count for a divide-by-2^d ratio.
  function automatic int unsigned div_last(input int unsigned d);
    return (32'd1 << d) - 32'd1;
  endfunction

  // Counting is frozen in stop-in-sleep or halting debug state.
  function automatic logic suspend_now(input logic slp, input logic sis,
                                       input logic dbg, input logic drun);
    return (slp & sis) | (dbg & ~drun);
  endfunction

endpackage

// File: rtl/tck_edge_sync.sv
module tck_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], pin};
      prev <= sh[STAGES-1];
    end
  end

  assign rise = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/tck_prescaler.sv
module tck_prescaler
  import tmr_clk_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [DIV_W-1:0] div,
  output logic             fire
);
  localparam int PW = (1 << DIV_W) - 1;

  logic [PW-1:0] pcnt;
  logic [PW-1:0] last;

  assign last = PW'(div_last(int'(div)));
  assign fire = tick & ~clr & (pcnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (clr) begin
      pcnt <= '0;
    end else if (tick) begin
      pcnt <= fire ? '0 : pcnt + PW'(1);
    end
  end
endmodule

// File: rtl/tck_downcnt.sv
module tck_downcnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] reload_val,
  input  logic          en,
  output logic [CW-1:0] count,
  output logic          underflow,
  output logic          running
);
  logic [CW-1:0] rl_q;
  logic          step;
  logic          wrap;

  assign step = en & running & ~start;
  assign wrap = step & (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '0;
      rl_q      <= '0;
      running   <= 1'b0;
      underflow <= 1'b0;
    end else begin
      underflow <= wrap;
      if (start) begin
        count   <= reload_val;
        rl_q    <= reload_val;
        running <= 1'b1;
      end else if (wrap) begin
        count <= rl_q;
      end else if (step) begin
        count <= count - CW'(1);
      end
    end
  end
endmodule

// File: rtl/tmr_clk_front.sv
module tmr_clk_front
  import tmr_clk_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int DIV_W         = 4,
  parameter int SYNC_STAGES   = 2,
  parameter bit EVENT_CAPABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       src_tick,
  input  logic             alt_tick,
  input  logic             ev_pin,
  input  logic [1:0]       sel,
  input  logic [DIV_W-1:0] div,
  input  logic             sleep_req,
  input  logic             stop_in_sleep,
  input  logic             debug_mode,
  input  logic             debug_run,
  input  logic             start,
  input  logic [CNT_W-1:0] reload_val,
  output logic             cnt_en,
  output logic [CNT_W-1:0] count,
  output logic             underflow
);
  logic [1:0]       sel_q;
  logic [DIV_W-1:0] div_q;
  logic             cfg_chg;
  logic             suspend;
  logic             event_mode;
  logic             raw_tick;
  logic             gated_tick;
  logic             pre_fire;
  logic             ev_rise;
  logic             run_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      div_q <= '0;
    end else begin
      sel_q <= sel;
      div_q <= div;
    end
  end

  assign cfg_chg    = (sel != sel_q) | (div != div_q);
  assign suspend    = suspend_now(sleep_req, stop_in_sleep, debug_mode, debug_run);
  assign event_mode = EVENT_CAPABLE && (src_sel_e'(sel) == SRC_ALT);

  generate
    if (EVENT_CAPABLE) begin : g_evt
      tck_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ev_pin),
        .rise (ev_rise)
      );
    end else begin : g_noevt
      assign ev_rise = 1'b0;
    end
  endgenerate

  always_comb begin
    case (src_sel_e'(sel))
      SRC_A:   raw_tick = src_tick[0];
      SRC_B:   raw_tick = src_tick[1];
      SRC_C:   raw_tick = src_tick[2];
      default: raw_tick = EVENT_CAPABLE ? 1'b0 : alt_tick;
    endcase
  end

  assign gated_tick = raw_tick & ~suspend;

  tck_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cfg_chg | start),
    .tick (gated_tick),
    .div  (div),
    .fire (pre_fire)
  );

  assign cnt_en = event_mode ? (ev_rise & ~suspend & ~start) : pre_fire;

  tck_downcnt #(.CW(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .reload_val(reload_val),
    .en        (cnt_en),
    .count     (count),
    .underflow (underflow),
    .running   (run_active)
  );
endmodule

// File: rtl/tmr_clk_front_chk.sv
module tmr_clk_front_chk #(
  parameter int CW  = 16,
  parameter bit EVT = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    sel,
  input logic          sleep_req,
  input logic          stop_in_sleep,
  input logic          debug_mode,
  input logic          debug_run,
  input logic          start,
  input logic [CW-1:0] reload_val,
  input logic          cnt_en,
  input logic [CW-1:0] count,
  input logic          underflow,
  input logic          ev_rise,
  input logic          run_active
);
  // R5
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && stop_in_sleep) |-> !cnt_en);

  // R7
  dbg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (debug_mode && !debug_run) |-> !cnt_en);

  // R11
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (count == $past(reload_val)));

  // R12
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && cnt_en && run_active && count == '0) |=> underflow);

  // R12
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $past(cnt_en));

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && cnt_en && run_active && count != '0) |=> (count == $past(count) - CW'(1)));

  // R9
  evt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (EVT && sel == 2'd3 && cnt_en) |-> ev_rise);
endmodule

bind tmr_clk_front tmr_clk_front_chk #(.CW(CNT_W), .EVT(EVENT_CAPABLE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel          (sel),
  .sleep_req    (sleep_req),
  .stop_in_sleep(stop_in_sleep),
  .debug_mode   (debug_mode),
  .debug_run    (debug_run),
  .start        (start),
  .reload_val   (reload_val),
  .cnt_en       (cnt_en),
  .count        (count),
  .underflow    (underflow),
  .ev_rise      (ev_rise),
  .run_active   (run_active)
);

// File: tb/tb_tmr_clk_front.sv
`timescale 1ns/1ps

module tb_ref_tmr #(
  parameter bit EVT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  src_tick,
  input  logic        alt_tick,
  input  logic        ev_pin,
  input  logic [1:0]  sel,
  input  logic [3:0]  div,
  input  logic        sleep_req,
  input  logic        stop_in_sleep,
  input  logic        debug_mode,
  input  logic        debug_run,
  input  logic        start,
  input  logic [15:0] reload_val,
  output logic        m_en,
  output logic [15:0] m_count,
  output logic        m_uf
);
  logic        s0, s1, s2;
  logic [1:0]  psel;
  logic [3:0]  pdiv;
  int unsigned left;
  logic [15:0] rl;
  logic        run;
  logic        halted, evmode, tk, changed;

  function automatic int unsigned period_m1(input logic [3:0] d);
    int unsigned p = 1;
    for (int i = 0; i < int'(d); i++) p = p * 2;
    return p - 1;
  endfunction

  always_comb begin
    halted  = (sleep_req && stop_in_sleep) || (debug_mode && !debug_run);
    evmode  = EVT && (sel == 2'd3);
    if (sel == 2'd3) tk = EVT ? 1'b0 : alt_tick;
    else             tk = src_tick[sel];
    changed = (psel != sel) || (pdiv != div);
    if (evmode) m_en = s1 && !s2 && !halted && !start;
    else        m_en = tk && !halted && !changed && !start && (left == 0);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 <= 0; s1 <= 0; s2 <= 0; psel <= 0; pdiv <= 0; left <= 0;
      rl <= 0; run <= 0; m_count <= 0; m_uf <= 0;
    end else begin
      s0 <= ev_pin; s1 <= s0; s2 <= s1;
      psel <= sel; pdiv <= div;
      if (changed || start) left <= period_m1(div);
      else if (tk && !halted) left <= (left == 0) ? period_m1(div) : left - 1;
      m_uf <= 1'b0;
      if (start) begin
        m_count <= reload_val; rl <= reload_val; run <= 1'b1;
      end else if (m_en && run) begin
        if (m_count == 16'd0) begin m_count <= rl; m_uf <= 1'b1; end
        else m_count <= m_count - 16'd1;
      end
    end
  end
endmodule

module tb_tmr_clk_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src_tick = '0;
  logic        alt_tick = 1'b0;
  logic        ev_pin = 1'b0;
  logic [1:0]  sel = '0;
  logic [3:0]  div = '0;
  logic        sleep_req = 1'b0, stop_in_sleep = 1'b0;
  logic        debug_mode = 1'b0, debug_run = 1'b0;
  logic        start = 1'b0;
  logic [15:0] reload_val = '0;

  logic        en_a, uf_a, en_b, uf_b;
  logic [15:0] cnt_a, cnt_b;
  logic        men_a, muf_a, men_b, muf_b;
  logic [15:0] mcnt_a, mcnt_b;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  tmr_clk_front #(.EVENT_CAPABLE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .alt_tick(alt_tick), .ev_pin(ev_pin),
    .sel(sel), .div(div), .sleep_req(sleep_req), .stop_in_sleep(stop_in_sleep),
    .debug_mode(debug_mode), .debug_run(debug_run), .start(start), .reload_val(reload_val),
    .cnt_en(en_a), .count(cnt_a), .underflow(uf_a));

  tmr_clk_front #(.EVENT_CAPABLE(1'b0)) dut_nx (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .alt_tick(alt_tick), .ev_pin(ev_pin),
    .sel(sel), .div(div), .sleep_req(sleep_req), .stop_in_sleep(stop_in_sleep),
    .debug_mode(debug_mode), .debug_run(debug_run), .start(start), .reload_val(reload_val),
    .cnt_en(en_b), .count(cnt_b), .underflow(uf_b));

  tb_ref_tmr #(.EVT(1'b1)) mdl_a (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .alt_tick(alt_tick), .ev_pin(ev_pin),
    .sel(sel), .div(div), .sleep_req(sleep_req), .stop_in_sleep(stop_in_sleep),
    .debug_mode(debug_mode), .debug_run(debug_run), .start(start), .reload_val(reload_val),
    .m_en(men_a), .m_count(mcnt_a), .m_uf(muf_a));

  tb_ref_tmr #(.EVT(1'b0)) mdl_b (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .alt_tick(alt_tick), .ev_pin(ev_pin),
    .sel(sel), .div(div), .sleep_req(sleep_req), .stop_in_sleep(stop_in_sleep),
    .debug_mode(debug_mode), .debug_run(debug_run), .start(start), .reload_val(reload_val),
    .m_en(men_b), .m_count(mcnt_b), .m_uf(muf_b));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // One clock; compare both channels to their models at the falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk(cur_tag, "evt count", cnt_a, mcnt_a);
    chk(cur_tag, "evt underflow", uf_a, muf_a);
    chk(cur_tag, "evt cnt_en", en_a, men_a);
    chk(cur_tag, "alt count", cnt_b, mcnt_b);
    chk(cur_tag, "alt underflow", uf_b, muf_b);
    chk(cur_tag, "alt cnt_en", en_b, men_b);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_start(input logic [15:0] v);
    reload_val = v; start = 1'b1;
    step();
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1: actual cycles 100000 expected completion earlier");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "count", cnt_a, 0);
    chk("R1", "underflow", uf_a, 0);
    chk("R1", "cnt_en", en_a, 0);

    // R11 no counting before start
    cur_tag = "R11";
    src_tick = 3'b001; steps(2);
    chk("R11", "count before start", cnt_a, 0);
    chk("R11", "underflow before start", uf_a, 0);
    src_tick = 3'b000;
    do_start(16'd10);
    chk("R11", "count after start", cnt_a, 10);

    // R2 source selection
    cur_tag = "R2";
    src_tick = 3'b010; steps(3);
    chk("R2", "unselected source", cnt_a, 10);
    src_tick = 3'b001; steps(3);
    chk("R2", "selected source", cnt_a, 7);
    src_tick = 3'b000;

    // R3 divide by 4
    cur_tag = "R3";
    div = 4'd2; do_start(16'd100);
    src_tick = 3'b001; steps(7);
    chk("R3", "after 7 ticks div4", cnt_a, 99);
    step();
    chk("R3", "after 8 ticks div4", cnt_a, 98);
    src_tick = 3'b000;

    // R4 prescaler restart on select change
    cur_tag = "R4";
    do_start(16'd100);
    src_tick = 3'b001; steps(2);
    sel = 2'd1; src_tick = 3'b111; step();
    chk("R4", "change cycle", cnt_a, 100);
    steps(3);
    chk("R4", "3 ticks after change", cnt_a, 100);
    step();
    chk("R4", "4 ticks after change", cnt_a, 99);
    src_tick = 3'b000; sel = 2'd0;

    // R5 stop in sleep, R6 run in sleep
    cur_tag = "R5";
    div = 4'd1; do_start(16'd50);
    src_tick = 3'b001; step();
    chk("R5", "half period", cnt_a, 50);
    sleep_req = 1'b1; stop_in_sleep = 1'b1; steps(5);
    chk("R5", "held in sleep", cnt_a, 50);
    sleep_req = 1'b0; step();
    chk("R5", "phase kept after wake", cnt_a, 49);
    cur_tag = "R6";
    sleep_req = 1'b1; stop_in_sleep = 1'b0; steps(2);
    chk("R6", "counting in sleep", cnt_a, 48);
    sleep_req = 1'b0;

    // R7 debug halt, R8 debug run
    cur_tag = "R7";
    debug_mode = 1'b1; debug_run = 1'b0; steps(4);
    chk("R7", "held in debug", cnt_a, 48);
    cur_tag = "R8";
    debug_run = 1'b1; steps(2);
    chk("R8", "counting in debug", cnt_a, 47);
    debug_mode = 1'b0; debug_run = 1'b0; src_tick = 3'b000;

    // R9 event pin counting, undivided
    cur_tag = "R9";
    sel = 2'd3; div = 4'd3; ev_pin = 1'b0; do_start(16'd20);
    ev_pin = 1'b1; steps(2);
    chk("R9", "before sync latency", cnt_a, 20);
    step();
    chk("R9", "third edge", cnt_a, 19);
    steps(3);
    chk("R9", "pin held high", cnt_a, 19);
    for (int k = 0; k < 4; k++) begin
      ev_pin = 1'b0; step();
      ev_pin = 1'b1; step();
    end
    steps(2);
    chk("R9", "four more edges", cnt_a, 15);
    chk("R10", "pin ignored without capability", cnt_b, 20);

    // R10 alternate oscillator through divider
    cur_tag = "R10";
    ev_pin = 1'b0; alt_tick = 1'b1; steps(7);
    chk("R10", "7 alt ticks div8", cnt_b, 20);
    step();
    chk("R10", "8 alt ticks div8", cnt_b, 19);
    chk("R10", "alt ignored on event channel", cnt_a, 15);
    alt_tick = 1'b0;

    // R12 wrap and underflow pulse
    cur_tag = "R12";
    sel = 2'd0; div = 4'd0; do_start(16'd2);
    src_tick = 3'b001; step();
    chk("R12", "count 1", cnt_a, 1);
    step();
    chk("R12", "count 0", cnt_a, 0);
    chk("R12", "no flag at 0", uf_a, 0);
    step();
    chk("R12", "reloaded", cnt_a, 2);
    chk("R12", "flag set", uf_a, 1);
    src_tick = 3'b000; step();
    chk("R12", "flag one cycle", uf_a, 0);
    chk("R12", "count kept", cnt_a, 2);

    // Random mix against the reference models
    cur_tag = "rand";
    for (int c = 0; c < 3000; c++) begin
      src_tick = 3'($urandom);
      alt_tick = 1'($urandom);
      if ($urandom_range(3) == 0) ev_pin = ~ev_pin;
      if ($urandom_range(39) == 0) sel = 2'($urandom);
      if ($urandom_range(39) == 0) div = 4'($urandom_range(3));
      if ($urandom_range(15) == 0) sleep_req = ~sleep_req;
      if ($urandom_range(15) == 0) stop_in_sleep = ~stop_in_sleep;
      if ($urandom_range(15) == 0) debug_mode = ~debug_mode;
      if ($urandom_range(15) == 0) debug_run = ~debug_run;
      start = ($urandom_range(149) == 0);
      reload_val = 16'($urandom_range(40));
      step();
    end

    summary();
    $finish;
  end
endmodule